// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave that gives an external master read and write access to a bank of twenty 8-bit control registers. The serial pins are chip select (active low), serial clock, serial data in and serial data out. All of them are sampled in the system clock domain through synchronizers, so the serial clock must run well below the system clock. Every access is a fixed 16-bit frame. It carries a 7-bit register address, then one direction bit, then one data byte, each field sent most significant bit first.

A write frame updates the addressed register and produces a one-cycle write strobe that carries the address and data for neighbouring logic. A read frame drives the addressed byte out on the data-out pin. The output-enable pin is high only during that read data phase, and the pad ring uses it to tri-state the pin at all other times. One slot is a read-only window onto a measurement value supplied by the surrounding chip. Writing any byte to the dedicated reset address returns every register to its default and raises a soft reset pulse.

Top module: `sreg_spi_slave`

## Requirements
- R1: A frame is 16 serial-clock rising edges with chip select low: address bits 6..0, then the direction bit, then data bits 7..0, all MSB first. Direction 1 is a write and direction 0 is a read, and a read changes no register.
- R2: A complete write frame to a writable address (00h to 12h) stores the data byte, and one system-clock pulse later `wr_stb` is high for exactly one cycle, with `wr_addr` and `wr_data` holding the frame's address and data.
- R3: In a read frame the addressed byte appears on `spi_miso` MSB first. Each bit is updated after a serial-clock falling edge and is stable at the following rising edge: bit 7 is valid at the 9th rising edge and bit 0 at the 16th.
- R4: `spi_miso_oe` is high only from the falling edge after the 8th rising edge of a read frame up to the falling edge after the 16th. It is low when idle, during the address phase and during write frames.
- R5: If chip select rises before the 16th rising edge, the frame is discarded: no register changes and no strobe is issued.
- R6: Serial-clock edges after the 16th within one chip-select period are ignored. The frame already received takes effect exactly once.
- R7: After hardware reset, register 0Fh holds 5Fh, register 10h holds 07h and every other register holds 00h.
- R8: A write of any data byte to address 60h returns every register to its R7 default and pulses `soft_rst` for one cycle. It does not pulse `wr_stb`.
- R9: Address 13h is read-only. A read returns the current `meas_val`, and a write changes nothing and issues no strobe.
- R10: Writes to undefined addresses (14h to 7Fh other than 60h) change no register and issue no strobe. Reads from any address above 13h return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_clk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| meas_val | input | 8 | Value shown by the read-only register 13h |
| reg_bank | output | 160 | All register slots, slot n at bits 8n+7..8n |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 7 | Address of the strobed write |
| wr_data | output | 8 | Data of the strobed write |
| soft_rst | output | 1 | One-cycle pulse on a write to the reset address |

## Verification
The situations hardest to reach from the ports are frames that do not match the 16-edge shape. One kind ends early, and the other keeps clocking after the data byte. Both are easy to miss because the bank looks unchanged, or correct, either way. The bench's transfer task takes an explicit edge count, so it can end a write at 10 or 15 edges, or run it to 20 edges with ones on the data line after the frame. It then compares the whole bank and the strobe counter against its own model. The read data phase is checked at every bit, including the output enable during the address phase, so a one-edge slip in the hand-over from address to data is visible.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 20;
  localparam int RO_INDEX  = 19;
  localparam int RST_ADDR  = 96;
  localparam int LEVEL_IDX = 15;
  localparam int FREQ_IDX  = 16;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    logic [DATA_W-1:0] v;
    case (idx)
      LEVEL_IDX: v = DATA_W'(8'h5F);
      FREQ_IDX:  v = DATA_W'(8'h07);
      default:   v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end

    assign sync_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);

  localparam int FRAME_LEN = ADDR_W + 1 + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_DIR  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(ADDR_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);

  logic                 sclk_d_q;
  logic                 rise, fall;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 dir_q, dir_d;
  logic [DATA_W-1:0]    tx_q, tx_d;
  logic                 oe_q, oe_d;
  logic                 wr_q, wr_d;

  assign rise = sclk_s & ~sclk_d_q;
  assign fall = ~sclk_s & sclk_d_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    dir_d = dir_q;
    tx_d  = tx_q;
    oe_d  = oe_q;
    wr_d  = 1'b0;
    if (csn_s) begin
      cnt_d = '0;
      dir_d = 1'b1;
      oe_d  = 1'b0;
    end else begin
      if (rise && (cnt_q < CNT_FULL)) begin
        sh_d  = {sh_q[FRAME_LEN-2:0], mosi_s};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_DIR) begin
          dir_d = mosi_s;
          tx_d  = rd_data;
        end
        if ((cnt_q == CNT_LAST) && dir_q) wr_d = 1'b1;
      end
      if (fall) begin
        if (!oe_q && !dir_q && (cnt_q == CNT_DATA)) begin
          oe_d = 1'b1;
        end else if (oe_q) begin
          if (cnt_q == CNT_FULL) oe_d = 1'b0;
          else                   tx_d = {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      dir_q    <= 1'b1;
      tx_q     <= '0;
      oe_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      dir_q    <= dir_d;
      tx_q     <= tx_d;
      oe_q     <= oe_d;
      wr_q     <= wr_d;
    end
  end

  assign rd_addr = sh_q[ADDR_W-1:0];
  assign wr_req  = wr_q;
  assign wr_addr = sh_q[FRAME_LEN-1 -: ADDR_W];
  assign wr_data = sh_q[DATA_W-1:0];
  assign miso    = tx_q[DATA_W-1];
  assign miso_oe = oe_q;

  AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> !dir_q); // R4
  AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !oe_q); // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q); // R2
  AST_WR_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> (cnt_q == CNT_FULL)); // R5

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 20,
  parameter int RO_INDEX = 19,
  parameter int RST_ADDR = 96
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_req,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [DATA_W-1:0]          meas_val,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] bank_flat,
  output logic                       wr_stb,
  output logic [ADDR_W-1:0]          wr_stb_addr,
  output logic [DATA_W-1:0]          wr_stb_data,
  output logic                       soft_rst
);

  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(RST_ADDR);
  localparam logic [ADDR_W-1:0] A_RO   = ADDR_W'(RO_INDEX);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(NUM_REGS);

  logic              soft_hit;
  logic              stb_d;
  logic              stb_q;
  logic [ADDR_W-1:0] stb_addr_q;
  logic [DATA_W-1:0] stb_data_q;
  logic              soft_q;

  assign soft_hit = wr_req && (wr_addr == A_RST);
  assign stb_d    = wr_req && (wr_addr < A_LIMIT) && (wr_addr != A_RO);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam logic [DATA_W-1:0] DEF = sreg_pkg::reg_default(i);
    if (i == RO_INDEX) begin : g_ro
      assign bank_flat[i*DATA_W +: DATA_W] = meas_val;
    end else begin : g_rw
      logic              hit;
      logic              en;
      logic [DATA_W-1:0] val_q, val_d;

      assign hit = wr_req && (wr_addr == ADDR_W'(i));
      assign en  = hit || soft_hit;

      always_comb begin
        val_d = val_q;
        if (soft_hit) val_d = DEF;
        else if (hit) val_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= DEF;
        else if (en) val_q <= val_d;
      end

      assign bank_flat[i*DATA_W +: DATA_W] = val_q;

      AST_STROBE_MATCHES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q && (stb_addr_q == ADDR_W'(i))) |-> (val_q == stb_data_q)); // R2
      AST_SOFT_GIVES_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |-> (val_q == DEF)); // R8
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_data = bank_flat[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q      <= 1'b0;
      stb_addr_q <= '0;
      stb_data_q <= '0;
      soft_q     <= 1'b0;
    end else begin
      stb_q  <= stb_d;
      soft_q <= soft_hit;
      if (stb_d) begin
        stb_addr_q <= wr_addr;
        stb_data_q <= wr_data;
      end
    end
  end

  assign wr_stb      = stb_q;
  assign wr_stb_addr = stb_addr_q;
  assign wr_stb_data = stb_data_q;
  assign soft_rst    = soft_q;

  AST_STROBE_LEGAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> ((stb_addr_q < A_LIMIT) && (stb_addr_q != A_RO))); // R10
  AST_SOFT_NOT_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |-> !stb_q); // R8

endmodule

// File: rtl/sreg_spi_slave.sv
module sreg_spi_slave #(
  parameter int ADDR_W      = sreg_pkg::ADDR_W,
  parameter int DATA_W      = sreg_pkg::DATA_W,
  parameter int NUM_REGS    = sreg_pkg::NUM_REGS,
  parameter int RO_INDEX    = sreg_pkg::RO_INDEX,
  parameter int RST_ADDR    = sreg_pkg::RST_ADDR,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_csn,
  input  logic                       spi_clk,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic                       spi_miso_oe,
  input  logic [DATA_W-1:0]          meas_val,
  output logic [NUM_REGS*DATA_W-1:0] reg_bank,
  output logic                       wr_stb,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data,
  output logic                       soft_rst
);

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] f_rd_addr;
  logic [DATA_W-1:0] f_rd_data;
  logic              f_wr_req;
  logic [ADDR_W-1:0] f_wr_addr;
  logic [DATA_W-1:0] f_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  sreg_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in ({spi_csn, spi_clk, spi_mosi}),
    .sync_out (pins_s)
  );

  sreg_frame #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .csn_s   (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .mosi_s  (pins_s[0]),
    .rd_data (f_rd_data),
    .rd_addr (f_rd_addr),
    .wr_req  (f_wr_req),
    .wr_addr (f_wr_addr),
    .wr_data (f_wr_data),
    .miso    (spi_miso),
    .miso_oe (spi_miso_oe)
  );

  sreg_bank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .RO_INDEX (RO_INDEX),
    .RST_ADDR (RST_ADDR)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_req      (f_wr_req),
    .wr_addr     (f_wr_addr),
    .wr_data     (f_wr_data),
    .rd_addr     (f_rd_addr),
    .meas_val    (meas_val),
    .rd_data     (f_rd_data),
    .bank_flat   (reg_bank),
    .wr_stb      (wr_stb),
    .wr_stb_addr (wr_addr),
    .wr_stb_data (wr_data),
    .soft_rst    (soft_rst)
  );

  AST_STROBE_AND_SOFT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(wr_stb && soft_rst)); // R8

endmodule

// File: tb/sreg_spi_slave_tb.sv
module sreg_spi_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int NREG       = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              spi_csn = 1'b1;
  logic              spi_clk = 1'b0;
  logic              spi_mosi = 1'b0;
  logic              spi_miso;
  logic              spi_miso_oe;
  logic [7:0]        meas_val = 8'h00;
  logic [NREG*8-1:0] reg_bank;
  logic              wr_stb;
  logic [6:0]        wr_addr;
  logic [7:0]        wr_data;
  logic              soft_rst;

  int n_checks = 0;
  int n_fails  = 0;
  int stb_cnt  = 0;
  int soft_cnt = 0;
  logic [6:0] last_addr = '0;
  logic [7:0] last_data = '0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  sreg_spi_slave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_clk     (spi_clk),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .meas_val    (meas_val),
    .reg_bank    (reg_bank),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .soft_rst    (soft_rst)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt   <= stb_cnt + 1;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
    if (soft_rst) soft_cnt <= soft_cnt + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  task automatic model_defaults();
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    model[15] = 8'h5F;
    model[16] = 8'h07;
  endtask

  task automatic check_bank(input string req);
    int bad = 0;
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] e = (i == 19) ? meas_val : model[i];
      if (reg_bank[i*8 +: 8] != e) begin
        bad++;
        $display("FAIL %s slot %0h: actual %0h expected %0h", req, i, reg_bank[i*8 +: 8], e);
      end
    end
    n_checks++;
    if (bad != 0) n_fails++;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One transfer of nbits edges; bits past 16 are driven as ones.
  task automatic xfer(input logic [6:0] addr, input logic wr, input logic [7:0] data,
                      input int nbits, output logic [7:0] rd, output int oe_bad);
    logic [15:0] frame = {addr, wr, data};
    rd = '0;
    oe_bad = 0;
    @(negedge clk);
    spi_csn = 1'b0;
    wait_clks(HALF_SCK);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = (b < 16) ? frame[15-b] : 1'b1;
      wait_clks(HALF_SCK);
      if (spi_miso_oe != ((!wr) && (b >= 8) && (b < 16))) oe_bad++;
      if (!wr && b >= 8 && b < 16) rd[15-b] = spi_miso;
      spi_clk = 1'b1;
      wait_clks(HALF_SCK);
      spi_clk = 1'b0;
    end
    wait_clks(HALF_SCK);
    if (spi_miso_oe) oe_bad++;
    spi_csn = 1'b1;
    wait_clks(8);
    if (spi_miso_oe) oe_bad++;
  endtask

  task automatic t_reset();
    model_defaults();
    check_bank("R7");
    check("R4", "oe idle after reset", spi_miso_oe, 0);
    check("R2", "no strobe after reset", stb_cnt, 0);
  endtask

  task automatic t_write_read(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rd; int oe_bad; int s0 = stb_cnt;
    xfer(a, 1'b1, d, 16, rd, oe_bad);
    model[a] = d;
    check_bank("R1");
    check("R2", "strobe count", stb_cnt, s0 + 1);
    check("R2", "strobe addr", last_addr, a);
    check("R2", "strobe data", last_data, d);
    check("R4", "oe during write", oe_bad, 0);
    xfer(a, 1'b0, 8'hFF, 16, rd, oe_bad);
    check("R3", "read back", rd, d);
    check("R4", "oe during read", oe_bad, 0);
    check("R1", "read makes no strobe", stb_cnt, s0 + 1);
    check_bank("R1");
  endtask

  task automatic t_truncated();
    logic [7:0] rd; int oe_bad; int s0 = stb_cnt;
    xfer(7'h05, 1'b1, 8'h77, 10, rd, oe_bad);
    xfer(7'h05, 1'b1, 8'h77, 15, rd, oe_bad);
    check_bank("R5");
    check("R5", "no strobe on short frame", stb_cnt, s0);
  endtask

  task automatic t_extra_edges();
    logic [7:0] rd; int oe_bad; int s0 = stb_cnt;
    xfer(7'h06, 1'b1, 8'h24, 20, rd, oe_bad);
    model[6] = 8'h24;
    check_bank("R6");
    check("R6", "single strobe", stb_cnt, s0 + 1);
    xfer(7'h06, 1'b0, 8'h00, 20, rd, oe_bad);
    check("R6", "long read data", rd, 8'h24);
    check("R6", "long read oe", oe_bad, 0);
  endtask

  task automatic t_readonly();
    logic [7:0] rd; int oe_bad; int s0 = stb_cnt;
    meas_val = 8'h9C;
    xfer(7'h13, 1'b0, 8'h00, 16, rd, oe_bad);
    check("R9", "read meas", rd, 8'h9C);
    xfer(7'h13, 1'b1, 8'h11, 16, rd, oe_bad);
    check("R9", "no strobe on ro write", stb_cnt, s0);
    meas_val = 8'h42;
    xfer(7'h13, 1'b0, 8'h00, 16, rd, oe_bad);
    check("R9", "read new meas", rd, 8'h42);
    check_bank("R9");
  endtask

  task automatic t_undefined();
    logic [7:0] rd; int oe_bad; int s0 = stb_cnt;
    xfer(7'h25, 1'b1, 8'hFF, 16, rd, oe_bad);
    xfer(7'h7F, 1'b1, 8'hAA, 16, rd, oe_bad);
    check_bank("R10");
    check("R10", "no strobe undefined", stb_cnt, s0);
    xfer(7'h25, 1'b0, 8'h00, 16, rd, oe_bad);
    check("R10", "read undefined", rd, 8'h00);
    xfer(7'h60, 1'b0, 8'h00, 16, rd, oe_bad);
    check("R10", "read reset address", rd, 8'h00);
    check("R8", "read of 60h no soft reset", soft_cnt, 0);
  endtask

  task automatic t_soft_reset();
    logic [7:0] rd; int oe_bad; int s0 = stb_cnt;
    xfer(7'h0F, 1'b1, 8'h00, 16, rd, oe_bad);
    model[15] = 8'h00;
    check_bank("R2");
    xfer(7'h60, 1'b1, 8'h3B, 16, rd, oe_bad);
    model_defaults();
    check_bank("R8");
    check("R8", "soft pulse count", soft_cnt, 1);
    check("R8", "no strobe for reset", stb_cnt, s0 + 1);
    xfer(7'h10, 1'b0, 8'h00, 16, rd, oe_bad);
    check("R7", "default 10h by read", rd, 8'h07);
    xfer(7'h0F, 1'b0, 8'h00, 16, rd, oe_bad);
    check("R7", "default 0Fh by read", rd, 8'h5F);
  endtask

  initial begin
    wait_clks(200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    model_defaults();
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(6);
    t_reset();
    t_write_read(7'h03, 8'hA5);
    t_write_read(7'h00, 8'h3C);
    t_write_read(7'h12, 8'h81);
    t_truncated();
    t_extra_edges();
    t_readonly();
    t_undefined();
    t_soft_reset();
    summary();
    $finish;
  end

endmodule